// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software by requiring it to reload a 7-bit down-counter at the right moment, neither too late nor too early. Once it is armed, the counter decrements once per prescaled timebase period. If software lets the counter fall from 0x40 to 0x3F, the block emits a one-cycle system-reset request. Software must reload the counter only after it has dropped to or below a programmable window value. A reload made while the counter is still above the window is treated as a fault and also produces a reset request. One count before expiry, an early-warning flag is raised and can drive an interrupt.

Software reaches the block through a word-addressed register port with three registers. The control register is at byte offset 0x00: the counter sits in bits 6:0 and the arm bit in bit 7. The configuration register is at 0x04: the window value sits in bits 6:0, the timebase select in bits 8:7 and the interrupt enable in bit 9. The status register is at 0x08, with the early-warning flag in bit 0. The arm bit and the interrupt enable can only be set by software. They clear only on the block's reset.

Top module: `winwdt`

## Requirements
- R1: After reset, the control register reads 0x7F (counter 0x7F, disarmed), the configuration register reads 0x7F, the status register reads 0, and both `rst_req` and `irq` are low.
- R2: While disarmed, the counter and the prescaler hold still. A control write only loads bits 6:0 into the counter and never raises `rst_req`.
- R3: Writing 1 to control bit 7 arms the block. Writing 0 to that bit afterwards leaves the block armed.
- R4: While armed, the counter decrements once every PRE_BASE×2^tb clocks after its last control write. Here tb is configuration bits 8:7, with 0, 1, 2 and 3 selecting ×1, ×2, ×4 and ×8. Any control write restarts this period.
- R5: When the counter decrements from 0x40 to 0x3F, `rst_req` is high for exactly the one clock that follows that edge.
- R6: A control write made while armed and while the counter is above the window value is rejected. `rst_req` pulses and the counter keeps its value.
- R7: A control write made while armed, with the counter at or below the window and with bit 6 of the written value set, loads the counter without raising `rst_req`.
- R8: An accepted control write that leaves the block armed (already armed, or bit 7 set in the write) and carries bit 6 clear still loads the counter, and `rst_req` pulses.
- R9: Status bit 0 sets when the counter decrements from 0x41 to 0x40. Writing 0 to bit 0 clears it, and writing 1 to bit 0 has no effect.
- R10: Configuration bit 9 enables the interrupt and, once set, ignores writes of 0. `irq` is high exactly when both the status flag and this enable are set.
- R11: `rd_data` is zero while `rd_en` is low. Otherwise it returns the addressed register, with unused bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the register; bits 3:2 select it |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Read data, combinational |
| rst_req | output | 1 | One-cycle reset request |
| irq | output | 1 | Early-warning interrupt |

## Verification
The properties assume that the register strobes are single-cycle and are driven synchronously to `clk`. They also assume that at most one register is written per cycle, which follows from the single address bus. The bench drives every strobe on the falling edge and releases it after one rising edge, so each write lands on exactly one edge. It chooses its write values so that each reload lands on a known side of the window. It also never changes the timebase in the middle of a measured decrement interval.

// File: rtl/winwdt_pkg.sv
package winwdt_pkg;

    localparam int CNT_W = 7;
    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t CNT_RESET  = 7'h7F;
    localparam cnt_t WIN_RESET  = 7'h7F;
    localparam cnt_t CNT_LAST   = 7'h40;  // decrement from here expires
    localparam cnt_t CNT_WARN   = 7'h41;  // decrement from here raises the flag

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_CFG  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       ewie;
        logic [1:0] tb;
        cnt_t       win;
    } cfg_t;

    function automatic reg_sel_e decode_sel(input logic [1:0] word_idx);
        case (word_idx)
            2'd0:    return SEL_CTRL;
            2'd1:    return SEL_CFG;
            2'd2:    return SEL_STAT;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/winwdt_presc.sv
module winwdt_presc #(
    parameter int PRE_BASE = 4096
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] tb,
    output logic       tick
);
    localparam int MAX_DIV = PRE_BASE * 8;
    localparam int PW      = $clog2(MAX_DIV) + 1;

    logic [PW-1:0] pcnt;
    logic [PW-1:0] limit;

    assign limit = PW'(PRE_BASE) << tb;
    assign tick  = run && !restart && (pcnt >= limit - PW'(1));

    always_ff @(posedge clk) begin
        if (rst || !run || restart || tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + PW'(1);
        end
    end
endmodule

// File: rtl/winwdt_regs.sv
module winwdt_regs
    import winwdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_cfg,
    input  logic       wr_ctrl,
    input  logic [9:0] wdata,
    output cfg_t       cfg,
    output logic       act
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '{ewie: 1'b0, tb: 2'd0, win: WIN_RESET};
            act <= 1'b0;
        end else begin
            if (wr_cfg) begin
                cfg.win  <= wdata[6:0];
                cfg.tb   <= wdata[8:7];
                cfg.ewie <= cfg.ewie | wdata[9];
            end
            if (wr_ctrl && wdata[7]) begin
                act <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/winwdt_core.sv
module winwdt_core
    import winwdt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic act,
    input  cnt_t win,
    input  logic tick,
    input  logic wr_ctrl,
    input  logic load_arm,
    input  cnt_t load_val,
    input  logic clr_flag,
    output cnt_t cnt,
    output logic flag,
    output logic rst_req
);
    logic early, accept, bad_load, expire, warn;

    always_comb begin
        early    = wr_ctrl && act && (cnt > win);
        accept   = wr_ctrl && !early;
        bad_load = accept && (act || load_arm) && !load_val[CNT_W-1];
        expire   = tick && (cnt == CNT_LAST);
        warn     = tick && (cnt == CNT_WARN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= CNT_RESET;
            flag    <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            if (accept) begin
                cnt <= load_val;
            end else if (tick) begin
                cnt <= cnt - cnt_t'(1);
            end
            if (warn) begin
                flag <= 1'b1;
            end else if (clr_flag) begin
                flag <= 1'b0;
            end
            rst_req <= early || bad_load || expire;
        end
    end
endmodule

// File: rtl/winwdt.sv
module winwdt
    import winwdt_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int PRE_BASE = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rst_req,
    output logic              irq
);
    reg_sel_e sel;
    logic     wr_ctrl, wr_cfg, clr_flag;
    cfg_t     cfg;
    logic     act, tick, flag;
    cnt_t     cnt;

    assign sel      = decode_sel(addr[3:2]);
    assign wr_ctrl  = wr_en && (sel == SEL_CTRL);
    assign wr_cfg   = wr_en && (sel == SEL_CFG);
    assign clr_flag = wr_en && (sel == SEL_STAT) && !wr_data[0];

    winwdt_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_cfg (wr_cfg),
        .wr_ctrl(wr_ctrl),
        .wdata  (wr_data[9:0]),
        .cfg    (cfg),
        .act    (act)
    );

    winwdt_presc #(.PRE_BASE(PRE_BASE)) u_presc (
        .clk    (clk),
        .rst    (rst),
        .run    (act),
        .restart(wr_ctrl),
        .tb     (cfg.tb),
        .tick   (tick)
    );

    winwdt_core u_core (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .win     (cfg.win),
        .tick    (tick),
        .wr_ctrl (wr_ctrl),
        .load_arm(wr_data[7]),
        .load_val(wr_data[6:0]),
        .clr_flag(clr_flag),
        .cnt     (cnt),
        .flag    (flag),
        .rst_req (rst_req)
    );

    assign irq = flag && cfg.ewie;

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (sel)
                SEL_CTRL: rd_data[7:0] = {act, cnt};
                SEL_CFG:  rd_data[9:0] = cfg;
                SEL_STAT: rd_data[0]   = flag;
                default:  rd_data      = '0;
            endcase
        end
    end
endmodule

// File: rtl/winwdt_chk.sv
module winwdt_chk
    import winwdt_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic act,
    input logic ewie,
    input cnt_t cnt,
    input cnt_t win,
    input logic tick,
    input logic wr_ctrl,
    input logic flag,
    input logic rst_req
);
    AST_ARM_STICKY: assert property (@(posedge clk) disable iff (rst)
        act |=> act);                                                  // R3

    AST_EWIE_STICKY: assert property (@(posedge clk) disable iff (rst)
        ewie |=> ewie);                                                // R10

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!act && !wr_ctrl) |=> $stable(cnt) && !rst_req);              // R2

    AST_EXPIRE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt == 7'h40) |=> (rst_req && cnt == 7'h3F));         // R5

    AST_EARLY_REJECT: assert property (@(posedge clk) disable iff (rst)
        (act && wr_ctrl && cnt > win) |=> (rst_req && $stable(cnt)));  // R6

    AST_WARN_FLAG: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt == 7'h41) |=> flag);                              // R9
endmodule

bind winwdt winwdt_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .act    (act),
    .ewie   (cfg.ewie),
    .cnt    (cnt),
    .win    (cfg.win),
    .tick   (tick),
    .wr_ctrl(wr_ctrl),
    .flag   (flag),
    .rst_req(rst_req)
);

// File: tb/winwdt_tb.sv
module winwdt_tb;
    localparam int PRE = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        rst_req, irq;

    int checks = 0;
    int failures = 0;
    int n_rst = 0;

    // behavioural reference state
    int m_cnt, m_win, m_tb, m_pc;
    bit m_act, m_ewie, m_flag, m_rst;

    always #5 clk = ~clk;

    winwdt #(.PRE_BASE(PRE)) u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rst_req(rst_req), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
        end
    endtask

    // reference model: advances on each rising edge from the stable inputs
    always @(posedge clk) begin
        bit set_now;
        set_now = 0;
        if (rst) begin
            m_cnt = 127; m_win = 127; m_tb = 0; m_pc = 0;
            m_act = 0; m_ewie = 0; m_flag = 0; m_rst = 0;
        end else begin
            m_rst = 0;
            if (wr_en && addr[3:2] == 2'd0) begin
                m_pc = 0;
                if (m_act && m_cnt > m_win) m_rst = 1;
                else begin
                    m_cnt = wr_data[6:0];
                    if ((m_act || wr_data[7]) && !wr_data[6]) m_rst = 1;
                end
                if (wr_data[7]) m_act = 1;
            end else if (m_act) begin
                m_pc++;
                if (m_pc >= PRE * (1 << m_tb)) begin
                    m_pc = 0;
                    if (m_cnt == 64) m_rst = 1;
                    if (m_cnt == 65) begin m_flag = 1; set_now = 1; end
                    m_cnt = (m_cnt - 1) & 127;
                end
            end
            if (wr_en && addr[3:2] == 2'd1) begin
                m_win = wr_data[6:0];
                m_tb = wr_data[8:7];
                if (wr_data[9]) m_ewie = 1;
            end
            if (wr_en && addr[3:2] == 2'd2 && !wr_data[0] && !set_now) m_flag = 0;
        end
    end

    // per-cycle comparison of the registered outputs
    always @(negedge clk) begin
        if (!rst) begin
            if (rst_req) n_rst++;
            check("R5/R6/R8 rst_req per cycle", {31'd0, rst_req}, {31'd0, m_rst});
            check("R10 irq per cycle", {31'd0, irq}, {31'd0, m_flag & m_ewie});
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        addr = a; rd_en = 1'b1;
        #1;
        check(tag, rd_data, exp);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int base;
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        rd(4'h0, 32'h7F, "R1 ctrl reset");
        rd(4'h4, 32'h7F, "R1 cfg reset");
        rd(4'h8, 32'h0, "R1 status reset");
        check("R1 irq reset", {31'd0, irq}, 32'd0);
        // R11 read strobe low gives zero
        addr = 4'h0; #1; check("R11 rd_en low", rd_data, 32'h0);
        // R2 disarmed load, frozen counter
        wr(4'h0, 32'h30);
        idle(1);
        check("R2 no rst while disarmed", n_rst, 0);
        idle(50);
        rd(4'h0, 32'h30, "R2 counter frozen");
        // R10 enable set then write of 0 ignored
        wr(4'h4, 32'h250);
        rd(4'h4, 32'h250, "R10 cfg write");
        wr(4'h4, 32'h050);
        rd(4'h4, 32'h250, "R10 ewie sticky");
        // R3 arm, then write with bit 7 clear
        wr(4'h0, 32'hC5);
        rd(4'h0, 32'hC5, "R3 armed");
        wr(4'h0, 32'h45);
        rd(4'h0, 32'hC5, "R3 R7 arm sticky, in-window reload");
        check("R7 no rst on in-window reload", n_rst, 0);
        // R4 decrement period
        idle(4);
        rd(4'h0, 32'hC4, "R4 one step after PRE clocks");
        idle(16);
        // R9 flag at 0x40
        rd(4'h0, 32'hC0, "R9 counter at 0x40");
        rd(4'h8, 32'h1, "R9 flag set");
        check("R10 irq raised", {31'd0, irq}, 32'd1);
        base = n_rst;
        wr(4'h8, 32'h1);
        rd(4'h8, 32'h1, "R9 write 1 ignored");
        wr(4'h8, 32'h0);
        rd(4'h8, 32'h0, "R9 write 0 clears");
        // R5 expiry
        idle(8);
        check("R5 single expiry pulse", n_rst, base + 1);
        // R6 early reload
        wr(4'h0, 32'hFF);
        rd(4'h0, 32'hFF, "R7 reload at low count");
        base = n_rst;
        wr(4'h0, 32'hFF);
        idle(1);
        check("R6 early reload pulses", n_rst, base + 1);
        rd(4'h0, 32'hFF, "R6 counter kept");
        // R8 reload with bit 6 clear
        idle(200);
        base = n_rst;
        wr(4'h0, 32'hB0);
        idle(1);
        check("R8 low load pulses", n_rst, base + 1);
        rd(4'h0, 32'hB0, "R8 value loaded");
        // R4 timebase x8
        wr(4'h4, 32'h3D0);
        rd(4'h4, 32'h3D0, "R4 timebase field");
        wr(4'h0, 32'h4A);
        idle(31);
        rd(4'h0, 32'hCA, "R4 no step before 32 clocks");
        idle(1);
        rd(4'h0, 32'hC9, "R4 step at 32 clocks");
        idle(5);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule